// File: doc/BRIEF.md
# Banked Line Control Register Decoder

This block owns the single register offset of a banked serial-port register map where the line format register and the bank pointer live together. A host write to that offset always loads the bank pointer. The same write loads the line format only when the top bit of the written byte is clear. When that bit is set, the line format is held, so software can move between banks without disturbing the serial format.

A read at the shared offset returns the bank pointer. The line format can be read back through a mirror at a fixed offset inside bank 3. The block decodes the bank pointer into a bank number for the rest of the register map. It also presents the line format fields as separate outputs for the serial datapath: data bits, stop length, parity controls and break.

Top module: `lcr_bank_decoder`

## Requirements
- R1: After reset the line format and the bank pointer are both 0x00, `bank` is 0, every line field output is at its zero setting (`word_bits` = 5), and a read at the shared offset returns 0x00.
- R2: A write at the shared offset (SHARED_OFS, default 3) with data bit 7 = 0 loads the byte into both the line format and the bank pointer. The result is visible after the clock edge that takes the write.
- R3: A write at the shared offset with data bit 7 = 1 loads only the bank pointer. Every line field output stays unchanged.
- R4: A read at the shared offset returns the bank pointer in the same cycle, whatever bank is selected.
- R5: When `bank` is 3, a read at SHADOW_OFS (default 4) returns the line format byte. Any read that is neither the shared offset nor this mirror returns 0x00.
- R6: The line format fields sit at these bit positions. Bits 1:0 give the word length: codes 00, 01, 10 and 11 drive `word_bits` to 5, 6, 7 and 8. Bit 2 drives `two_stop`, bit 3 drives `parity_en`, bit 4 drives `parity_even`, bit 5 drives `parity_stick` and bit 6 drives `break_out`.
- R7: On a write at the shared offset, the written byte sets the bank as follows. Bit 7 = 0 selects bank 0. 0x80 selects bank 1. 0xE0 + k, for k from 0 to 4, selects bank 2 + k. Any other byte leaves `bank` unchanged.
- R8: A write at any offset other than the shared offset changes neither register nor `bank`. The shared offset is decoded the same way in every bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write strobe |
| addr | input | ADDR_W (3) | Register offset within the current bank |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| bank | output | BANK_W (3) | Currently selected bank |
| word_bits | output | 4 | Data bits per character (5 to 8) |
| two_stop | output | 1 | Long stop setting |
| parity_en | output | 1 | Parity enabled |
| parity_even | output | 1 | Even parity selected |
| parity_stick | output | 1 | Stick parity selected |
| break_out | output | 1 | Force break on the line |

## Verification
A write is taken at a rising edge, and its effects on `bank`, on the line field outputs and on read data all appear right after that same edge. Reads are combinational and are due in the cycle in which `addr` is presented. The bench drives every input on the falling edge and samples one half-cycle after the edge that takes a write. It checks reads after a short settling delay inside the same cycle, so each result is sampled where it is due and never across an edge.

// File: rtl/lcr_bank_decoder.sv
module lcr_bank_decoder #(
  parameter int ADDR_W      = 3,
  parameter int BANK_W      = 3,
  parameter int SHARED_OFS  = 3,
  parameter int SHADOW_OFS  = 4,
  parameter int SHADOW_BANK = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic [BANK_W-1:0] bank,
  output logic [3:0]        word_bits,
  output logic              two_stop,
  output logic              parity_en,
  output logic              parity_even,
  output logic              parity_stick,
  output logic              break_out
);

  localparam logic [ADDR_W-1:0] SH_A  = ADDR_W'(SHARED_OFS);
  localparam logic [ADDR_W-1:0] MIR_A = ADDR_W'(SHADOW_OFS);
  localparam logic [BANK_W-1:0] MIR_B = BANK_W'(SHADOW_BANK);

  logic [7:0]        fmt_q, ptr_q;
  logic [BANK_W-1:0] bank_q, bank_nxt;
  logic              hit_wr;

  assign hit_wr = wr_en && (addr == SH_A);

  always_comb begin
    bank_nxt = bank_q;
    if (!wr_data[7])
      bank_nxt = '0;
    else if (wr_data == 8'h80)
      bank_nxt = BANK_W'(1);
    else if (wr_data[7:3] == 5'b11100 && wr_data[2:0] <= 3'd4)
      bank_nxt = BANK_W'(wr_data[2:0]) + BANK_W'(2);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_q  <= '0;
      ptr_q  <= '0;
      bank_q <= '0;
    end else if (hit_wr) begin
      ptr_q  <= wr_data;
      bank_q <= bank_nxt;
      if (!wr_data[7]) fmt_q <= wr_data;
    end
  end

  always_comb begin
    if (addr == SH_A)
      rd_data = ptr_q;
    else if (bank_q == MIR_B && addr == MIR_A)
      rd_data = fmt_q;
    else
      rd_data = '0;
  end

  assign bank         = bank_q;
  assign word_bits    = 4'd5 + {2'b00, fmt_q[1:0]};
  assign two_stop     = fmt_q[2];
  assign parity_en    = fmt_q[3];
  assign parity_even  = fmt_q[4];
  assign parity_stick = fmt_q[5];
  assign break_out    = fmt_q[6];

  AST_FMT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SH_A && !wr_data[7]) |=> (fmt_q == $past(wr_data) && bank == '0)); // R2
  AST_FMT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SH_A && wr_data[7]) |=> ($stable(word_bits) && $stable(break_out) && $stable(parity_en))); // R3
  AST_READ_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SH_A) |=> (addr != SH_A || rd_data == $past(wr_data))); // R4
  AST_BANK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SH_A && wr_data[7] && wr_data != 8'h80 && !(wr_data >= 8'hE0 && wr_data <= 8'hE4))
    |=> $stable(bank)); // R7
  AST_OTHER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == SH_A) |=> ($stable(fmt_q) && $stable(ptr_q) && $stable(bank))); // R8

endmodule

// File: tb/lcr_bank_decoder_tb_top.sv
module lcr_bank_decoder_tb_top;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [2:0] bank;
  logic [3:0] word_bits;
  logic two_stop, parity_en, parity_even, parity_stick, break_out;

  int checks = 0, errors = 0;
  logic [7:0] fmt_m = 0, ptr_m = 0;
  logic [2:0] bank_m = 0;

  always #2 clk = ~clk;

  lcr_bank_decoder dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .bank(bank), .word_bits(word_bits),
    .two_stop(two_stop), .parity_en(parity_en), .parity_even(parity_even),
    .parity_stick(parity_stick), .break_out(break_out));

  function automatic logic [2:0] exp_bank(logic [2:0] cur, logic [7:0] d);
    if (!d[7]) return 3'd0;
    if (d == 8'h80) return 3'd1;
    if (d >= 8'hE0 && d <= 8'hE4) return 3'(d - 8'hE0 + 8'd2);
    return cur;
  endfunction

  function automatic logic [7:0] exp_read(logic [2:0] a);
    if (a == 3'd3) return ptr_m;
    if (bank_m == 3'd3 && a == 3'd4) return fmt_m;
    return 8'h00;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_fields(string tag);
    chk({tag, " word_bits"}, 32'(word_bits), 32'(4'd5 + {2'b0, fmt_m[1:0]}));
    chk({tag, " flags"}, 32'({break_out, parity_stick, parity_even, parity_en, two_stop}),
        32'(fmt_m[6:2]));
  endtask

  task automatic do_write(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (a == 3'd3) begin
      if (!d[7]) fmt_m = d;
      ptr_m = d;
      bank_m = exp_bank(bank_m, d);
    end
  endtask

  task automatic do_read(string tag, logic [2:0] a);
    addr = a;
    #1;
    chk(tag, 32'(rd_data), 32'(exp_read(a)));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 bank", 32'(bank), 0);
    chk_fields("R1");
    do_read("R1 read shared", 3'd3);

    do_write(3'd3, 8'h1B);
    chk_fields("R2");
    chk("R2 bank", 32'(bank), 0);
    do_write(3'd3, 8'h80);
    chk_fields("R3");
    chk("R7 bank 0x80", 32'(bank), 1);
    do_read("R4 read ptr in bank1", 3'd3);
    do_write(3'd3, 8'hE1);
    chk("R7 bank 0xE1", 32'(bank), 3);
    do_read("R5 shadow", 3'd4);
    do_read("R5 other zero", 3'd5);
    do_write(3'd3, 8'hE5);
    chk("R7 keep on 0xE5", 32'(bank), 3);
    do_read("R4 read 0xE5", 3'd3);
    do_write(3'd3, 8'hC0);
    chk("R7 keep on 0xC0", 32'(bank), 3);
    chk_fields("R3 after 0xC0");
    do_write(3'd2, 8'h55);
    do_read("R8 shadow intact", 3'd4);
    do_read("R8 ptr intact", 3'd3);
    do_write(3'd3, 8'hE4);
    chk("R7 bank 0xE4", 32'(bank), 6);
    do_write(3'd3, 8'h7F);
    chk_fields("R6 all set");
    chk("R7 bank cleared", 32'(bank), 0);
    for (int w = 0; w < 4; w++) begin
      do_write(3'd3, 8'(w));
      chk_fields("R6 word length");
    end

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      logic [2:0] a;
      int sel;
      sel = int'($urandom % 6);
      case (sel)
        0: d = 8'h80;
        1: d = 8'hE0 + 8'($urandom % 6);
        2: d = 8'($urandom) & 8'h7F;
        default: d = 8'($urandom);
      endcase
      a = ($urandom % 3 == 0) ? 3'($urandom) : 3'd3;
      do_write(a, d);
      chk("R7 bank rand", 32'(bank), 32'(bank_m));
      chk_fields((a == 3'd3 && d[7]) ? "R3 rand" : "R2 rand");
      do_read("R4 rand", 3'd3);
      do_read("R5 rand", 3'($urandom));
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
  end
endmodule